// File: doc/BRIEF.md
# Partially Subblocked Translation Buffer

This block is a small fully associative translation cache. Each entry covers an aligned group of four consecutive virtual pages. The entry holds one tag, one frame-block number and a four-bit residency mask. The physical frames of the group form one aligned block. Virtual page `tag*4+k` therefore maps to physical page `frame*4+k`, but only when mask bit `k` is set. If the bit is clear, the lookup misses even though the tag matches.

A page-table walker fills entries in the same format it reads from memory: tag, frame block and mask. A fill whose tag is already cached rewrites that entry. Any other fill takes the slot at a round-robin pointer. When one more page of an already cached group is brought in, a separate port sets that single residency bit. A flush invalidates the whole buffer in one cycle. Lookups are purely combinational.

Top module: `pstlb`

## Requirements
- R1: After reset every entry is invalid, every lookup misses, and the replacement pointer is at slot 0.
- R2: A lookup hits only if three conditions hold: the entry is valid, its tag equals `lk_vpn[VPN_W-1:2]`, and its mask bit `lk_vpn[1:0]` is 1. The result follows `lk_vpn` in the same cycle.
- R3: On a hit `lk_ppn` is `{frame, lk_vpn[1:0]}`. On a miss `lk_ppn` is 0.
- R4: A fill stores its tag, frame and mask, and a lookup sees them from the cycle after the fill.
- R5: A fill whose tag matches a valid entry replaces that entry's frame and its whole mask. The mask is replaced, not merged. This fill does not move the replacement pointer.
- R6: A fill with no matching tag writes the slot at the pointer, whatever that slot holds. The pointer then advances by one and wraps from 15 to 0.
- R7: A set request whose tag matches a valid entry sets mask bit `set_vpn[1:0]` and leaves the frame and other bits unchanged. A set request with no matching tag has no effect.
- R8: A flush clears every entry in one cycle and returns the pointer to slot 0. A fill or set in the same cycle is dropped.
- R9: When a fill and a set arrive in the same cycle, the fill is applied and the set is dropped.
- R10: No two valid entries ever hold the same tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_hit | output | 1 | Translation valid |
| lk_ppn | output | PPN_W | Translated physical page number, 0 on a miss |
| fill_valid | input | 1 | Fill request strobe |
| fill_tag | input | VPN_W-2 | Group tag (virtual page number without its low 2 bits) |
| fill_frame | input | PPN_W-2 | Aligned frame-block number |
| fill_mask | input | 4 | Residency mask, bit k for page k of the group |
| set_valid | input | 1 | Residency-bit set strobe |
| set_vpn | input | VPN_W | Virtual page whose residency bit is set |
| flush | input | 1 | Invalidate all entries |

## Verification
The hardest condition to reach from the ports is a round-robin eviction that depends on pointer history. For example, a repeated fill of a cached tag must not use up a slot. This cannot be seen directly, because only lookups expose the contents. The stimulus flushes to reach a known pointer position and fills the same tag twice. It then fills enough distinct tags to fill every slot, and uses lookups to show which tag survives and which one the next fill evicts. Simultaneous fill/set and flush/fill cycles are driven directly to show which request wins.

// File: rtl/pstlb.sv
module pstlb #(
  parameter int VPN_W   = 36,
  parameter int PPN_W   = 28,
  parameter int ENTRIES = 16,
  parameter int SUB_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_hit,
  output logic [PPN_W-1:0]   lk_ppn,
  input  logic               fill_valid,
  input  logic [VPN_W-SUB_W-1:0] fill_tag,
  input  logic [PPN_W-SUB_W-1:0] fill_frame,
  input  logic [(1<<SUB_W)-1:0]  fill_mask,
  input  logic               set_valid,
  input  logic [VPN_W-1:0]   set_vpn,
  input  logic               flush
);
  localparam int TAG_W = VPN_W - SUB_W;
  localparam int FRM_W = PPN_W - SUB_W;
  localparam int SUB   = 1 << SUB_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [FRM_W-1:0]   frm_q  [ENTRIES];
  logic [SUB-1:0]     mask_q [ENTRIES];
  logic [IDX_W-1:0]   ptr_q;

  logic [ENTRIES-1:0] lk_eq, lk_sel, fl_eq, st_eq, wr_en, st_en;
  logic [FRM_W-1:0]   frm_sel;
  logic               fill_go, fl_any, alloc;

  wire [TAG_W-1:0] lk_tag = lk_vpn[VPN_W-1:SUB_W];
  wire [SUB_W-1:0] lk_off = lk_vpn[SUB_W-1:0];
  wire [TAG_W-1:0] st_tag = set_vpn[VPN_W-1:SUB_W];
  wire [SUB_W-1:0] st_off = set_vpn[SUB_W-1:0];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign lk_eq[i]  = vld_q[i] && (tag_q[i] == lk_tag);
    assign lk_sel[i] = lk_eq[i] && mask_q[i][lk_off];
    assign fl_eq[i]  = vld_q[i] && (tag_q[i] == fill_tag);
    assign st_eq[i]  = vld_q[i] && (tag_q[i] == st_tag);
    assign wr_en[i]  = fill_go && (fl_any ? fl_eq[i] : (ptr_q == IDX_W'(i)));
    assign st_en[i]  = set_valid && !fill_valid && !flush && st_eq[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[i]  <= 1'b0;
        tag_q[i]  <= '0;
        frm_q[i]  <= '0;
        mask_q[i] <= '0;
      end else if (flush) begin
        vld_q[i]  <= 1'b0;
      end else if (wr_en[i]) begin
        vld_q[i]  <= 1'b1;
        tag_q[i]  <= fill_tag;
        frm_q[i]  <= fill_frame;
        mask_q[i] <= fill_mask;
      end else if (st_en[i]) begin
        mask_q[i] <= mask_q[i] | (SUB'(1) << st_off);
      end
    end
  end

  assign fill_go = fill_valid && !flush;
  assign fl_any  = |fl_eq;
  assign alloc   = fill_go && !fl_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_q <= '0;
    else if (flush) ptr_q <= '0;
    else if (alloc) ptr_q <= (ptr_q == IDX_W'(ENTRIES-1)) ? '0 : ptr_q + 1'b1;
  end

  always_comb begin
    frm_sel = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lk_sel[i]) frm_sel = frm_sel | frm_q[i];
  end

  assign lk_hit = |lk_sel;
  assign lk_ppn = lk_hit ? {frm_sel, lk_off} : '0;
endmodule

// File: rtl/pstlb_chk.sv
module pstlb_chk #(
  parameter int VPN_W   = 36,
  parameter int PPN_W   = 28,
  parameter int ENTRIES = 16,
  parameter int SUB_W   = 2,
  parameter int IDX_W   = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     flush,
  input logic                     fill_valid,
  input logic [VPN_W-SUB_W-1:0]   fill_tag,
  input logic [PPN_W-SUB_W-1:0]   fill_frame,
  input logic [(1<<SUB_W)-1:0]    fill_mask,
  input logic [VPN_W-1:0]         lk_vpn,
  input logic                     lk_hit,
  input logic [PPN_W-1:0]         lk_ppn,
  input logic [ENTRIES-1:0]       lk_eq,
  input logic                     alloc,
  input logic [IDX_W-1:0]         ptr_q
);
  assert_unique_tag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_eq));

  assert_miss_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_ppn == '0));

  assert_offset_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_ppn[SUB_W-1:0] == lk_vpn[SUB_W-1:0]));

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);

  assert_fill_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !flush && lk_vpn[VPN_W-1:SUB_W] == fill_tag && fill_mask[lk_vpn[SUB_W-1:0]])
    |=> (!$stable(lk_vpn) || (lk_hit && lk_ppn[PPN_W-1:SUB_W] == $past(fill_frame))));

  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> (ptr_q == (($past(ptr_q) == IDX_W'(ENTRIES-1)) ? '0 : $past(ptr_q) + 1'b1)));
endmodule

bind pstlb pstlb_chk #(
  .VPN_W(VPN_W), .PPN_W(PPN_W), .ENTRIES(ENTRIES), .SUB_W(SUB_W), .IDX_W(IDX_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .flush(flush), .fill_valid(fill_valid),
  .fill_tag(fill_tag), .fill_frame(fill_frame), .fill_mask(fill_mask),
  .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_eq(lk_eq),
  .alloc(alloc), .ptr_q(ptr_q)
);

// File: tb/pstlb_tb_top.sv
module pstlb_tb_top;
  localparam int VW = 36;
  localparam int PW = 28;

  logic clk = 0, rst_n = 0;
  logic [VW-1:0] lk_vpn = '0, set_vpn = '0;
  logic lk_hit;
  logic [PW-1:0] lk_ppn;
  logic fill_valid = 0, set_valid = 0, flush = 0;
  logic [VW-3:0] fill_tag = '0;
  logic [PW-3:0] fill_frame = '0;
  logic [3:0] fill_mask = '0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pstlb dut_i (.clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
    .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_frame(fill_frame), .fill_mask(fill_mask),
    .set_valid(set_valid), .set_vpn(set_vpn), .flush(flush));

  typedef struct packed {
    logic [1:0]    op;
    logic [VW-1:0] a;
    logic [PW-3:0] fr;
    logic [3:0]    bm;
    logic [VW-1:0] q;
    logic          eh;
    logic [PW-1:0] ep;
    logic [3:0]    req;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{2'd1, 36'h10, 26'h29, 4'b0101, 36'h40, 1'b1, 28'h0A4, 4'd4},  // R4 fill, R3 offset 0
    '{2'd0, 36'h0,  26'h0,  4'b0,    36'h41, 1'b0, 28'h0,   4'd2},  // R2 absent page misses
    '{2'd0, 36'h0,  26'h0,  4'b0,    36'h42, 1'b1, 28'h0A6, 4'd3},  // R3 offset 2
    '{2'd2, 36'h41, 26'h0,  4'b0,    36'h41, 1'b1, 28'h0A5, 4'd7},  // R7 set bit 1
    '{2'd2, 36'h85, 26'h0,  4'b0,    36'h85, 1'b0, 28'h0,   4'd7},  // R7 set without tag
    '{2'd1, 36'h21, 26'hFC, 4'b1000, 36'h87, 1'b1, 28'h3F3, 4'd4},  // R4 second entry
    '{2'd0, 36'h0,  26'h0,  4'b0,    36'h84, 1'b0, 28'h0,   4'd2},  // R2
    '{2'd1, 36'h10, 26'h80, 4'b0010, 36'h41, 1'b1, 28'h201, 4'd5},  // R5 overwrite
    '{2'd0, 36'h0,  26'h0,  4'b0,    36'h40, 1'b0, 28'h0,   4'd5},  // R5 mask replaced
    '{2'd0, 36'h0,  26'h0,  4'b0,    36'h87, 1'b1, 28'h3F3, 4'd5},  // R5 other entry kept
    '{2'd3, 36'h0,  26'h0,  4'b0,    36'h87, 1'b0, 28'h0,   4'd8},  // R8 flush
    '{2'd0, 36'h0,  26'h0,  4'b0,    36'h41, 1'b0, 28'h0,   4'd8}   // R8
  };

  task automatic chk(input int r, input logic eh, input logic [PW-1:0] ep);
    checks++;
    if (lk_hit !== eh || lk_ppn !== ep) begin
      errors++;
      $display("FAIL R%0d hit=%0b ppn=%h expected hit=%0b ppn=%h", r, lk_hit, lk_ppn, eh, ep);
    end
  endtask

  task automatic look(input logic [VW-1:0] v);
    lk_vpn = v;
    #1;
  endtask

  task automatic fill(input logic [VW-3:0] t, input logic [PW-3:0] f, input logic [3:0] m);
    @(negedge clk);
    fill_valid = 1; fill_tag = t; fill_frame = f; fill_mask = m;
    @(posedge clk); #1;
    fill_valid = 0;
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    lk_vpn = v.q;
    case (v.op)
      2'd1: begin fill_valid = 1; fill_tag = v.a[VW-3:0]; fill_frame = v.fr; fill_mask = v.bm; end
      2'd2: begin set_valid = 1; set_vpn = v.a; end
      2'd3: flush = 1;
      default: ;
    endcase
    @(posedge clk); #1;
    fill_valid = 0; set_valid = 0; flush = 0;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    look(36'h40); chk(1, 0, 0);               // R1 reset: miss
    @(negedge clk); rst_n = 1;
    look(36'h0);  chk(1, 0, 0);               // R1

    foreach (VECS[i]) begin
      drive(VECS[i]);
      chk(VECS[i].req, VECS[i].eh, VECS[i].ep);
    end

    // R5/R6: repeated fill must not consume a slot; pointer restarts after flush (R8)
    fill(34'h100, 26'h100, 4'hF);
    fill(34'h100, 26'h111, 4'hF);
    for (int k = 1; k < 16; k++) fill(34'h100 + k, 26'h100 + k, 4'hF);
    look({34'h100, 2'd2}); chk(5, 1, {26'h111, 2'd2});
    look({34'h10F, 2'd3}); chk(6, 1, {26'h10F, 2'd3});
    fill(34'h200, 26'h2AA, 4'b0001);            // R6 evicts slot 0 (tag 0x100)
    look({34'h100, 2'd0}); chk(6, 0, 0);
    look({34'h200, 2'd0}); chk(6, 1, {26'h2AA, 2'd0});
    look({34'h101, 2'd1}); chk(6, 1, {26'h101, 2'd1});
    fill(34'h201, 26'h2BB, 4'b0001);            // R6 evicts slot 1 (tag 0x101)
    look({34'h101, 2'd1}); chk(6, 0, 0);
    look({34'h102, 2'd1}); chk(6, 1, {26'h102, 2'd1});

    // R9: fill and set together, set dropped
    @(negedge clk);
    fill_valid = 1; fill_tag = 34'h300; fill_frame = 26'h30; fill_mask = 4'b0001;
    set_valid = 1; set_vpn = {34'h200, 2'd3};
    @(posedge clk); #1; fill_valid = 0; set_valid = 0;
    look({34'h200, 2'd3}); chk(9, 0, 0);
    look({34'h300, 2'd0}); chk(9, 1, {26'h30, 2'd0});
    // R7: set on a cached group keeps its frame
    @(negedge clk); set_valid = 1; set_vpn = {34'h200, 2'd3};
    @(posedge clk); #1; set_valid = 0;
    look({34'h200, 2'd3}); chk(7, 1, {26'h2AA, 2'd3});
    look({34'h200, 2'd0}); chk(7, 1, {26'h2AA, 2'd0});

    // R8: flush wins over fill in same cycle
    @(negedge clk);
    flush = 1; fill_valid = 1; fill_tag = 34'h400; fill_frame = 26'h40; fill_mask = 4'hF;
    @(posedge clk); #1; flush = 0; fill_valid = 0;
    look({34'h400, 2'd0}); chk(8, 0, 0);
    look({34'h300, 2'd0}); chk(8, 0, 0);
    // R10: refilling after flush yields one clean entry
    fill(34'h300, 26'h31, 4'b0011);
    fill(34'h300, 26'h32, 4'b0011);
    look({34'h300, 2'd1}); chk(10, 1, {26'h32, 2'd1});

    // R1: asynchronous reset mid-run clears contents
    @(negedge clk); rst_n = 0; #1;
    look({34'h300, 2'd1}); chk(1, 0, 0);
    @(negedge clk); rst_n = 1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule